// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block holds the trial register and the sequencing for an n-bit successive-approximation analog-to-digital converter. The DAC, the comparator and the sample-and-hold are outside the block. A one-cycle start request begins a binary search. The current trial word goes to the DAC on `dac_o`. The comparator answer comes back on `cmp_i`. The block decides one bit per step, starting at the most significant bit and ending at the least significant bit.

While the search runs, `hold_o` keeps the external sample-and-hold frozen, so the analog value stays constant. When the last bit is decided, `hold_o` drops and `valid_o` rises. The finished code is shown on `result_o`. Sequencing then stops, and only a new start request in the idle state begins another search.

A DAC that needs time to settle is handled by the `SETTLE` parameter (0 to 3). It adds that many wait cycles between applying a trial word and sampling the comparator. With `SETTLE` = 0 the block decides one bit per clock, so a 10-bit result takes 10 clocks.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, `dac_o` and `result_o` are 0, and `valid_o` and `hold_o` are low.
- R2: A start pulse sampled while `hold_o` is low loads `dac_o` with only its top bit set (half scale). From the next cycle it raises `hold_o` and clears `valid_o`.
- R3: `cmp_i` = 1 means the analog value is at or above the DAC word, and the bit under trial stays 1. `cmp_i` = 0 clears that bit. Bits already decided never change during the search.
- R4: Bits are tried strictly from the most significant to the least significant. After each decision the next lower bit is set as the new trial bit, and all bits below the trial bit are 0.
- R5: Decisions are spaced `SETTLE`+1 clocks apart. `valid_o` rises exactly `WIDTH`*(`SETTLE`+1) clocks after the start edge.
- R6: The comparator is sampled only at the last cycle of each settle window, so a DAC whose output lags by `SETTLE` cycles still yields the exact code.
- R7: At completion, `result_o` equals the code that the binary search settles on, and `dac_o` shows the same value. For an ideal DAC and comparator this code is the integer analog value.
- R8: Once complete, with no start request, `dac_o`, `result_o` and `valid_o` keep their values for any number of cycles.
- R9: A start pulse received while `hold_o` is high is ignored. The search continues with unchanged timing and result.
- R10: `hold_o` is high from the cycle after the start edge until the cycle in which `valid_o` rises, and is low otherwise. `hold_o` and `valid_o` are never high together.
- R11: A start after completion clears `valid_o` and begins a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-conversion request, one cycle |
| cmp_i | input | 1 | Comparator result, 1 when the analog value is at or above the DAC word |
| dac_o | output | WIDTH | Trial word to the external DAC |
| result_o | output | WIDTH | Last completed conversion code |
| valid_o | output | 1 | Result valid, held until the next start |
| hold_o | output | 1 | Keeps the external sample-and-hold frozen during a search |

## Verification
The bench builds the block with `WIDTH` = 8 and `SETTLE` = 2. This makes every one of the 256 codes cheap to convert, so the full range can be swept, including the all-zero and all-one extremes. A settle window of three clocks also lets the bench model a DAC that lags by two cycles. A block that sampled the comparator one cycle early would then produce wrong codes. The block is also checked with start requests injected in the middle of a search, with the source value changing while it is held, and with idle gaps of varying length between conversions.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    // Largest supported number of DAC settle cycles per trial
    localparam int unsigned SETTLE_MAX = 3;

    // Counter wide enough for SETTLE_MAX
    localparam int unsigned SETTLE_CW = $clog2(SETTLE_MAX + 1);

    typedef logic [SETTLE_CW-1:0] settle_cnt_t;

endpackage

// File: rtl/sar_settle_timer.sv
module sar_settle_timer
    import sar_adc_pkg::*;
#(
    parameter int unsigned SETTLE = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic ready_o
);

    generate
        if (SETTLE == 0) begin : g_no_wait
            logic unused_timer;
            assign unused_timer = ^{clk, rst_n, load_i};
            assign ready_o = 1'b1;
        end else begin : g_wait
            settle_cnt_t cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (load_i) begin
                    cnt_d = settle_cnt_t'(SETTLE);
                end else if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign ready_o = (cnt_q == '0);
        end
    endgenerate

endmodule

// File: rtl/sar_bit_slice.sv
module sar_bit_slice (
    input  logic cur_i,     // present value of this bit
    input  logic trial_i,   // this bit is the one under test
    input  logic next_i,    // this bit becomes the next trial bit
    input  logic decide_i,  // a decision is taken this cycle
    input  logic cmp_i,     // analog at or above DAC word
    output logic nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        if (decide_i) begin
            if (trial_i) begin
                nxt_o = cmp_i;
            end else if (next_i) begin
                nxt_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int unsigned WIDTH  = 10,
    parameter int unsigned SETTLE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] dac_o,
    output logic [WIDTH-1:0] result_o,
    output logic             valid_o,
    output logic             hold_o
);

    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] trial;   // word driven to the DAC
        logic [WIDTH-1:0] ptr;     // one-hot bit under test
        logic [WIDTH-1:0] result;  // last finished code
        logic             busy;
        logic             valid;
    } sar_state_t;

    sar_state_t st_d, st_q;

    logic             load_timer;
    logic             timer_ready;
    logic             decide;
    logic [WIDTH-1:0] slice_nxt;

    assign decide = st_q.busy & timer_ready;

    sar_settle_timer #(
        .SETTLE (SETTLE)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_timer),
        .ready_o (timer_ready)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_slice
        logic next_here;
        if (b == WIDTH - 1) begin : g_top
            assign next_here = 1'b0;
        end else begin : g_low
            assign next_here = st_q.ptr[b+1];
        end

        sar_bit_slice i_slice (
            .cur_i    (st_q.trial[b]),
            .trial_i  (st_q.ptr[b]),
            .next_i   (next_here),
            .decide_i (decide),
            .cmp_i    (cmp_i),
            .nxt_o    (slice_nxt[b])
        );
    end

    always_comb begin
        st_d       = st_q;
        load_timer = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.trial = TOP_BIT;
                st_d.ptr   = TOP_BIT;
                st_d.busy  = 1'b1;
                st_d.valid = 1'b0;
                load_timer = 1'b1;
            end
        end else if (decide) begin
            st_d.trial = slice_nxt;
            if (st_q.ptr[0]) begin
                st_d.ptr    = '0;
                st_d.busy   = 1'b0;
                st_d.valid  = 1'b1;
                st_d.result = slice_nxt;
            end else begin
                st_d.ptr   = st_q.ptr >> 1;
                load_timer = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_o    = st_q.trial;
    assign result_o = st_q.result;
    assign valid_o  = st_q.valid;
    assign hold_o   = st_q.busy;

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int unsigned WIDTH = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             cmp_i,
    input logic [WIDTH-1:0] dac_o,
    input logic [WIDTH-1:0] result_o,
    input logic             valid_o,
    input logic             hold_o
);

    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic unused_chk;
    assign unused_chk = cmp_i;

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_o && valid_o));

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_o && start_i) |=> (hold_o && !valid_o && dac_o == TOP_BIT));

    assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && start_i) |=> (hold_o || valid_o));

    assert_trial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> (dac_o != '0));

    assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> ($past(hold_o) && result_o == dac_o));

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_o && !start_i) |=> ($stable(dac_o) && $stable(result_o) && $stable(valid_o)));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.WIDTH(WIDTH)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cmp_i    (cmp_i),
    .dac_o    (dac_o),
    .result_o (result_o),
    .valid_o  (valid_o),
    .hold_o   (hold_o)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;

    localparam int W   = 8;
    localparam int S   = 2;
    localparam int LAT = W * (S + 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] src = '0;
    logic [W-1:0] held, lag1, lag2;
    logic         cmp;
    logic [W-1:0] dac, result;
    logic         valid, hold;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // External sample-and-hold and a DAC whose output lags by S cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
            lag1 <= '0;
            lag2 <= '0;
        end else begin
            if (!hold) held <= src;
            lag1 <= dac;
            lag2 <= lag1;
        end
    end
    assign cmp = (held >= lag2);

    sar_adc_ctrl #(.WIDTH(W), .SETTLE(S)) i_sar_adc_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .cmp_i    (cmp),
        .dac_o    (dac),
        .result_o (result),
        .valid_o  (valid),
        .hold_o   (hold)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic convert(input logic [W-1:0] a, input bit poke, input int idle);
        int  edges;
        bit  hold_ok, order_ok, was_valid;
        logic [W-1:0] keep_r, keep_d, mask;
        was_valid = valid;
        src   = a;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(dac == {1'b1, {(W-1){1'b0}}} && hold && !valid, "R2", int'(dac), 1 << (W-1));
        if (was_valid) chk(!valid, "R11", int'(valid), 0);
        edges = 0;
        hold_ok = 1'b1;
        order_ok = 1'b1;
        while (!valid && edges < LAT + 5) begin
            start = (poke && edges == LAT / 2);
            src = W'($urandom);
            @(posedge clk);
            edges++;
            @(negedge clk);
            start = 1'b0;
            if (!valid) begin
                int idx;
                if (!hold) hold_ok = 1'b0;
                idx = W - 1 - edges / (S + 1);
                mask = ({{(W-1){1'b0}}, 1'b1} << idx) - 1'b1;
                // R3: decided upper bits match; R4: trial bit set, lower bits clear
                if (!dac[idx] || (dac & mask) != '0 ||
                    (dac >> (idx + 1)) != (a >> (idx + 1))) order_ok = 1'b0;
            end
        end
        chk(edges == LAT, "R5", edges, LAT);
        chk(hold_ok && !hold, "R10", int'(hold), 0);
        chk(order_ok, "R3 R4", int'(dac), int'(a));
        chk(result == a && dac == a, "R7 R6", int'(result), int'(a));
        if (poke) chk(edges == LAT && result == a, "R9", int'(result), int'(a));
        keep_r = result;
        keep_d = dac;
        hold_ok = 1'b1;
        for (int i = 0; i < idle; i++) begin
            src = W'($urandom);
            @(posedge clk);
            @(negedge clk);
            if (result != keep_r || dac != keep_d || !valid || hold) hold_ok = 1'b0;
        end
        chk(hold_ok, "R8", int'(result), int'(keep_r));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dac == '0 && result == '0 && !valid && !hold, "R1", int'(dac), 0);
        // directed extremes first
        convert('0, 1'b0, 3);
        convert('1, 1'b1, 2);
        convert({1'b1, {(W-1){1'b0}}}, 1'b0, 0);
        convert({1'b0, {(W-1){1'b1}}}, 1'b1, 1);
        // full sweep of codes
        for (int a = 0; a < (1 << W); a++) begin
            convert(W'(a), (a % 7) == 3, a % 5);
        end
        // random codes with random idle gaps and injected starts
        for (int n = 0; n < 80; n++) begin
            convert(W'($urandom), 1'($urandom), int'($urandom % 6));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule